// File: doc/BRIEF.md
# Dual-Address Dual-Port RAM with Port-to-Port Pass-Through

This block is a synchronous memory with two data ports, X and Y, on one clock. Each port has its own address. A port can read, write, or forward its input word to the other port, and both ports act in the same cycle. Each port has two chip enables, one active low and one active high, an active-low write strobe and an active-low pass-through request. All of these are captured on the rising clock edge together with the address and the input data. Read and forwarded data reach the port through an output register. Each port's output enable is combinational and works without the clock.

A bidirectional data pin is split into three signals: an input bus, an output bus and a drive flag. Outside logic builds the tri-state buffer from them. The address width is a parameter. The full-size array uses 17 address bits (128K words of 36 bits). The default is kept small for simulation.

When both ports hit the same address, fixed rules apply. A read returns the contents from before a write made in the same cycle. When both ports write the same address, port Y's word is the one stored.

Top module: `dual_addr_xfer_ram`

## Requirements
- R1: A port is selected only when its `_en_n` input is 0 and its `_en` input is 1 at the clock edge. A port that is not selected writes nothing to the array, and its output register is not loaded by a read.
- R2: A selected port with `_wr_n` = 0 stores its `_din` at its `_addr`.
- R3: A selected port with `_wr_n` = 1 and `_pass_n` = 1 reads. The word at the address captured at edge n appears on its `_dout` after edge n+1, and not after edge n.
- R4: A selected port with `_pass_n` = 0 sends its captured `_din` to the other port's `_dout` after the next edge. This uses the same two-edge latency as a read, and works in both directions.
- R5: On the receiving port, pass-through data wins over that port's own read in the same cycle.
- R6: When both ports read the same address in one cycle, both return the stored word.
- R7: When one port writes and the other reads the same address in one cycle, the reader gets the old contents. The new word is stored and is visible to later reads.
- R8: When both ports write the same address in one cycle, port Y's data is stored and port X's data is dropped.
- R9: `_drive` equals the inverse of `_oe_n` at all times, without waiting for a clock edge.
- R10: A port's `_dout` holds its value across an edge when that port did not read and the other port did not pass to it.
- R11: Reset clears both output registers to 0 and leaves both ports deselected.
- R12: A port may write and pass in the same cycle. The word is stored at its address and also appears on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_addr | input | AW | Port X address |
| x_din | input | DW | Port X input data |
| x_en_n | input | 1 | Port X enable, active low |
| x_en | input | 1 | Port X enable, active high |
| x_wr_n | input | 1 | Port X write strobe, active low |
| x_pass_n | input | 1 | Port X pass-through to Y, active low |
| x_oe_n | input | 1 | Port X output enable, active low, combinational |
| x_dout | output | DW | Port X output register |
| x_drive | output | 1 | Port X pin drive flag |
| y_addr | input | AW | Port Y address |
| y_din | input | DW | Port Y input data |
| y_en_n | input | 1 | Port Y enable, active low |
| y_en | input | 1 | Port Y enable, active high |
| y_wr_n | input | 1 | Port Y write strobe, active low |
| y_pass_n | input | 1 | Port Y pass-through to X, active low |
| y_oe_n | input | 1 | Port Y output enable, active low, combinational |
| y_dout | output | DW | Port Y output register |
| y_drive | output | 1 | Port Y pin drive flag |

## Verification
The first test writes distinct words through X and Y at different addresses and then reads them crossed over. This separates each port's write path from its read path. The bench also samples one edge early to pin down the two-edge latency. Same-address cycles cover both-read, write-against-read in each direction, and double write. Together these separate read-before-write ordering from write-through, and show which port wins a double write. Pass-through is tried in each direction while the receiving port is reading, and again combined with a write. This shows forwarded data replacing array data, and also shows the sender's own output holding. The bench also checks half-enabled ports and the combinational output enables.

// File: rtl/dual_addr_xfer_ram.sv
module dual_addr_xfer_ram #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] x_addr,
  input  logic [DW-1:0] x_din,
  input  logic          x_en_n,
  input  logic          x_en,
  input  logic          x_wr_n,
  input  logic          x_pass_n,
  input  logic          x_oe_n,
  output logic [DW-1:0] x_dout,
  output logic          x_drive,
  input  logic [AW-1:0] y_addr,
  input  logic [DW-1:0] y_din,
  input  logic          y_en_n,
  input  logic          y_en,
  input  logic          y_wr_n,
  input  logic          y_pass_n,
  input  logic          y_oe_n,
  output logic [DW-1:0] y_dout,
  output logic          y_drive
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          xs_r, xw_r, xp_r, ys_r, yw_r, yp_r;
  logic [AW-1:0] xa_r, ya_r;
  logic [DW-1:0] xd_r, yd_r, xq, yq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_r <= 1'b0; xw_r <= 1'b0; xp_r <= 1'b0;
      ys_r <= 1'b0; yw_r <= 1'b0; yp_r <= 1'b0;
      xa_r <= '0;   ya_r <= '0;
      xd_r <= '0;   yd_r <= '0;
    end else begin
      xs_r <= ~x_en_n & x_en;
      xw_r <= ~x_wr_n;
      xp_r <= ~x_pass_n;
      xa_r <= x_addr;
      xd_r <= x_din;
      ys_r <= ~y_en_n & y_en;
      yw_r <= ~y_wr_n;
      yp_r <= ~y_pass_n;
      ya_r <= y_addr;
      yd_r <= y_din;
    end
  end

  logic x_rd, y_rd, x_wr, y_wr, x_tx, y_tx, x_wr_ok;

  assign x_rd    = xs_r & ~xw_r & ~xp_r;
  assign y_rd    = ys_r & ~yw_r & ~yp_r;
  assign x_wr    = xs_r & xw_r;
  assign y_wr    = ys_r & yw_r;
  assign x_tx    = xs_r & xp_r;
  assign y_tx    = ys_r & yp_r;
  assign x_wr_ok = x_wr & ~(y_wr && (xa_r == ya_r));

  always_ff @(posedge clk) begin
    if (x_wr_ok) mem[xa_r] <= xd_r;
    if (y_wr)    mem[ya_r] <= yd_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xq <= '0;
      yq <= '0;
    end else begin
      if (y_tx)      xq <= yd_r;
      else if (x_rd) xq <= mem[xa_r];
      if (x_tx)      yq <= xd_r;
      else if (y_rd) yq <= mem[ya_r];
    end
  end

  assign x_dout  = xq;
  assign y_dout  = yq;
  assign x_drive = ~x_oe_n;
  assign y_drive = ~y_oe_n;
endmodule

module dual_addr_xfer_ram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] x_din,
  input logic          x_en_n,
  input logic          x_en,
  input logic          x_wr_n,
  input logic          x_pass_n,
  input logic [DW-1:0] x_dout,
  input logic [DW-1:0] y_din,
  input logic          y_en_n,
  input logic          y_en,
  input logic          y_wr_n,
  input logic          y_pass_n,
  input logic [DW-1:0] y_dout
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic x_sel, y_sel, x_send, y_send, x_read, y_read;
  assign x_sel  = ~x_en_n & x_en;
  assign y_sel  = ~y_en_n & y_en;
  assign x_send = x_sel & ~x_pass_n;
  assign y_send = y_sel & ~y_pass_n;
  assign x_read = x_sel & x_wr_n & x_pass_n;
  assign y_read = y_sel & y_wr_n & y_pass_n;

  a_r4_x_to_y: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(x_send, 2)) |-> y_dout == $past(x_din, 2));

  a_r4_y_to_x: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(y_send, 2)) |-> x_dout == $past(y_din, 2));

  a_r10_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(x_read, 2) && !$past(y_send, 2)) |-> x_dout == $past(x_dout));

  a_r10_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(y_read, 2) && !$past(x_send, 2)) |-> y_dout == $past(y_dout));
endmodule

bind dual_addr_xfer_ram dual_addr_xfer_ram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .x_din(x_din), .x_en_n(x_en_n), .x_en(x_en), .x_wr_n(x_wr_n),
  .x_pass_n(x_pass_n), .x_dout(x_dout),
  .y_din(y_din), .y_en_n(y_en_n), .y_en(y_en), .y_wr_n(y_wr_n),
  .y_pass_n(y_pass_n), .y_dout(y_dout)
);

// File: tb/sim_dual_addr_xfer_ram.sv
module sim_dual_addr_xfer_ram;
  localparam int DW = 36;
  localparam int AW = 6;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] x_addr, y_addr;
  logic [DW-1:0] x_din, y_din, x_dout, y_dout;
  logic          x_en_n, x_en, x_wr_n, x_pass_n, x_oe_n, x_drive;
  logic          y_en_n, y_en, y_wr_n, y_pass_n, y_oe_n, y_drive;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [1<<AW];

  dual_addr_xfer_ram #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .x_addr(x_addr), .x_din(x_din), .x_en_n(x_en_n), .x_en(x_en),
    .x_wr_n(x_wr_n), .x_pass_n(x_pass_n), .x_oe_n(x_oe_n),
    .x_dout(x_dout), .x_drive(x_drive),
    .y_addr(y_addr), .y_din(y_din), .y_en_n(y_en_n), .y_en(y_en),
    .y_wr_n(y_wr_n), .y_pass_n(y_pass_n), .y_oe_n(y_oe_n),
    .y_dout(y_dout), .y_drive(y_drive)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setx(input logic sel, input logic wr, input logic pass,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    x_en_n = ~sel; x_en = sel; x_wr_n = ~wr; x_pass_n = ~pass; x_addr = a; x_din = d;
  endtask

  task automatic sety(input logic sel, input logic wr, input logic pass,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    y_en_n = ~sel; y_en = sel; y_wr_n = ~wr; y_pass_n = ~pass; y_addr = a; y_din = d;
  endtask

  task automatic idle();
    setx(1'b0, 1'b0, 1'b0, '0, '0);
    sety(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // apply the current inputs for one edge, then idle until the output register has updated
  task automatic run_op();
    step(); idle(); step();
  endtask

  task automatic t_reset();
    chk("R11 x_dout in reset", x_dout, '0);
    chk("R11 y_dout in reset", y_dout, '0);
    rst_n = 1'b1;
    step(); step();
    chk("R11 x_dout after reset", x_dout, '0);
    chk("R11 y_dout after reset", y_dout, '0);
  endtask

  task automatic t_write_read();
    setx(1, 1, 0, 6'd3, 36'hA_1111_0003);
    sety(1, 1, 0, 6'd5, 36'hB_2222_0005);
    ref_mem[3] = 36'hA_1111_0003;
    ref_mem[5] = 36'hB_2222_0005;
    run_op();
    chk("R10 x holds while writing", x_dout, '0);
    chk("R10 y holds while writing", y_dout, '0);
    setx(1, 0, 0, 6'd5, '0);
    sety(1, 0, 0, 6'd3, '0);
    step(); idle();
    chk("R3 x not yet loaded after one edge", x_dout, '0);
    step();
    chk("R2 R3 x reads Y's write", x_dout, ref_mem[5]);
    chk("R2 R3 y reads X's write", y_dout, ref_mem[3]);
  endtask

  task automatic t_select();
    x_en_n = 1; x_en = 1; x_wr_n = 0; x_pass_n = 1; x_addr = 6'd3; x_din = 36'hC_0000_0001;
    y_en_n = 0; y_en = 0; y_wr_n = 1; y_pass_n = 1; y_addr = 6'd5; y_din = '0;
    step();
    x_en_n = 0; x_en = 0; x_wr_n = 0; x_addr = 6'd3; x_din = 36'hC_0000_0002;
    y_en_n = 1; y_en = 1; y_wr_n = 0; y_addr = 6'd5; y_din = 36'hC_0000_0003;
    run_op();
    chk("R1 R10 x holds when half enabled", x_dout, ref_mem[5]);
    chk("R1 R10 y holds when half enabled", y_dout, ref_mem[3]);
    setx(1, 0, 0, 6'd3, '0);
    sety(1, 0, 0, 6'd5, '0);
    run_op();
    chk("R1 addr 3 not written by deselected X", x_dout, ref_mem[3]);
    chk("R1 addr 5 not written by deselected Y", y_dout, ref_mem[5]);
  endtask

  task automatic t_both_read();
    setx(1, 0, 0, 6'd5, '0);
    sety(1, 0, 0, 6'd5, '0);
    run_op();
    chk("R6 x same-address read", x_dout, ref_mem[5]);
    chk("R6 y same-address read", y_dout, ref_mem[5]);
  endtask

  task automatic t_rw_same();
    sety(1, 1, 0, 6'd7, 36'hF_0000_0007);
    setx(1, 0, 0, 6'd0, '0);
    ref_mem[7] = 36'hF_0000_0007;
    run_op();
    setx(1, 1, 0, 6'd7, 36'hE_0000_0007);
    sety(1, 0, 0, 6'd7, '0);
    run_op();
    chk("R7 y reads old word while X writes", y_dout, 36'hF_0000_0007);
    ref_mem[7] = 36'hE_0000_0007;
    sety(1, 1, 0, 6'd7, 36'h9_0000_0007);
    setx(1, 0, 0, 6'd7, '0);
    run_op();
    chk("R7 x reads old word while Y writes", x_dout, 36'hE_0000_0007);
    ref_mem[7] = 36'h9_0000_0007;
    setx(1, 0, 0, 6'd7, '0);
    sety(1, 0, 0, 6'd7, '0);
    run_op();
    chk("R7 new word stored", x_dout, 36'h9_0000_0007);
    chk("R7 new word stored (y)", y_dout, 36'h9_0000_0007);
  endtask

  task automatic t_ww_same();
    setx(1, 1, 0, 6'd9, 36'h1_1111_1111);
    sety(1, 1, 0, 6'd9, 36'h2_2222_2222);
    ref_mem[9] = 36'h2_2222_2222;
    run_op();
    setx(1, 0, 0, 6'd9, '0);
    run_op();
    chk("R8 Y wins double write", x_dout, 36'h2_2222_2222);
  endtask

  task automatic t_pass();
    logic [DW-1:0] xprev;
    xprev = x_dout;
    setx(1, 0, 1, 6'd0, 36'h5_AAAA_5555);
    sety(1, 0, 0, 6'd5, '0);
    run_op();
    chk("R4 R5 X passes to Y over Y's read", y_dout, 36'h5_AAAA_5555);
    chk("R10 sender X holds", x_dout, xprev);
    setx(1, 0, 0, 6'd5, '0);
    sety(1, 0, 1, 6'd7, 36'h6_BBBB_6666);
    run_op();
    chk("R4 R5 Y passes to X over X's read", x_dout, 36'h6_BBBB_6666);
    chk("R10 sender Y holds", y_dout, 36'h5_AAAA_5555);
  endtask

  task automatic t_wr_pass();
    setx(1, 1, 1, 6'd11, 36'h7_1234_5678);
    ref_mem[11] = 36'h7_1234_5678;
    run_op();
    chk("R12 write+pass reaches Y", y_dout, 36'h7_1234_5678);
    setx(1, 0, 0, 6'd11, '0);
    run_op();
    chk("R12 write+pass stored", x_dout, ref_mem[11]);
  endtask

  task automatic t_oe();
    x_oe_n = 1'b0; #1;
    chk("R9 x drive on", {35'd0, x_drive}, 36'd1);
    chk("R9 y drive still off", {35'd0, y_drive}, 36'd0);
    y_oe_n = 1'b0; x_oe_n = 1'b1; #1;
    chk("R9 x drive off", {35'd0, x_drive}, 36'd0);
    chk("R9 y drive on", {35'd0, y_drive}, 36'd1);
    y_oe_n = 1'b1; #1;
    chk("R9 y drive off", {35'd0, y_drive}, 36'd0);
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 'x;
    idle();
    x_oe_n = 1'b1; y_oe_n = 1'b1;
    step(); step();
    t_reset();
    t_write_read();
    t_select();
    t_both_read();
    t_rw_same();
    t_ww_same();
    t_pass();
    t_wr_pass();
    t_oe();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule